// File: doc/BRIEF.md
# Modulated Phase-Accumulating Sine Oscillator

This block is the oscillator core of a direct digital synthesizer. A wide phase accumulator advances once per clock by a frequency step. The step is a center frequency word plus an offset frequency word, and the offset word can be switched in and out by a single enable pin. Toggling that pin moves the output between two tones, which gives frequency-shift keying.

Two select pins add a quarter-turn multiple to the phase before it is looked up. This gives four-phase keying without disturbing the accumulator. The top bits of the shifted phase address a quarter-wave sine table, which is mirrored and negated to cover the full turn. A signed amplitude sample leaves the block on every clock, ready for a converter.

Top module: `qmod_nco`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the stored phase select and every pipeline stage. `amp_out` is 0 while reset is held and on the first clock after it is released.
- R2: On each clock outside reset, the 48-bit accumulator adds `center_fw`, plus `offset_fw` when `offset_en` is 1.
- R3: When `offset_en` is 0, the value of `offset_fw` has no effect on the accumulator or on any later sample.
- R4: The accumulator sum is taken modulo 2^48, so it wraps around without saturating. A center word of 2^48-k therefore makes the phase run backwards by k per clock.
- R5: `quad_sel` codes 0, 1, 2 and 3 add 0, 2^12, 2^13 and 3·2^12 (that is 0°, 90°, 180° and 270°) to the 14-bit lookup address. The accumulator is never altered, so returning to code 0 gives back the unshifted sample.
- R6: The lookup address p is bits 47..34 of the accumulator plus the quadrant term, taken modulo 2^14. The sample is round(8191·sin(2π(p+0.5)/16384)), in 14-bit two's complement, and never equals -8192.
- R7: Inputs sampled at clock edge n affect the accumulator at edge n. They first show up on `amp_out` after edge n+2, so the latency is three clocks.
- R8: The table holds one quarter wave. Addresses p and p+8192 give exactly negated samples, and addresses in the upper half give strictly negative samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| center_fw | input | 48 | Center frequency step |
| offset_fw | input | 48 | Offset frequency step |
| offset_en | input | 1 | Adds the offset step when 1, drops it when 0 |
| quad_sel | input | 2 | Quadrant phase offset code |
| amp_out | output | 14 | Signed sine amplitude sample |

## Verification
A change on any input shows at the output after exactly three rising edges. This holds for the frequency words, the offset enable and the quadrant code alike. The bench keeps a model that runs on the same rising edges and carries a two-stage expected pipeline. It compares the output at each falling edge, so every sample is checked in the cycle its inputs make it due. Directed steps confirm the three-edge delay explicitly: the output holds for two falling edges after a quadrant change and moves on the third. The symmetry checks wait four cycles after each change before sampling.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // Rounded magnitude of entry k of a quarter-wave table of a 2^addr_w-point turn
  function automatic int unsigned quarter_mag(int unsigned k, int unsigned addr_w,
                                              int unsigned peak);
    real theta;
    theta = TWO_PI * (real'(k) + 0.5) / real'(64'd1 << addr_w);
    return int'($rtoi(real'(peak) * $sin(theta) + 0.5));
  endfunction
endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int PHASE_W = 48,
  parameter int ADDR_W  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] center_fw,
  input  logic [PHASE_W-1:0] offset_fw,
  input  logic               offset_en,
  input  logic [1:0]         quad_sel,
  output logic [ADDR_W-1:0]  phase_top,
  output logic [1:0]         sel_q
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] step;

  assign step = center_fw + (offset_en ? offset_fw : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sel_q <= '0;
    end else begin
      acc_q <= acc_q + step;
      sel_q <= quad_sel;
    end
  end

  assign phase_top = acc_q[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/nco_quarter_sine.sv
module nco_quarter_sine #(
  parameter int ADDR_W = 14,
  parameter int OUT_W  = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [OUT_W-1:0]  amp
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAG_W = OUT_W - 1;
  localparam int PEAK  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] table_mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++)
      table_mem[k] = MAG_W'(nco_pkg::quarter_mag(k, ADDR_W, PEAK));
  end

  logic [IDX_W-1:0] idx;
  logic [MAG_W-1:0] mag_q;
  logic [1:0]       quad_q;
  logic signed [OUT_W-1:0] mag_s;

  // odd quadrants read the table backwards
  assign idx = addr[ADDR_W-2] ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) mag_q <= '0;
    else     mag_q <= table_mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) quad_q <= '0;
    else     quad_q <= addr[ADDR_W-1 -: 2];
  end

  assign mag_s = {1'b0, mag_q};

  always_ff @(posedge clk) begin
    if (rst)            amp <= '0;
    else if (quad_q[1]) amp <= -mag_s;
    else                amp <= mag_s;
  end
endmodule

// File: rtl/qmod_nco.sv
module qmod_nco #(
  parameter int PHASE_W = 48,
  parameter int ADDR_W  = 14,
  parameter int OUT_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] center_fw,
  input  logic [PHASE_W-1:0] offset_fw,
  input  logic               offset_en,
  input  logic [1:0]         quad_sel,
  output logic [OUT_W-1:0]   amp_out
);
  logic [ADDR_W-1:0] phase_top;
  logic [1:0]        sel_q;
  logic [ADDR_W-1:0] phase_addr;
  logic signed [OUT_W-1:0] amp_s;

  nco_phase_accum #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst),
    .center_fw(center_fw), .offset_fw(offset_fw), .offset_en(offset_en),
    .quad_sel(quad_sel), .phase_top(phase_top), .sel_q(sel_q)
  );

  assign phase_addr = phase_top + {sel_q, {(ADDR_W-2){1'b0}}};

  nco_quarter_sine #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_sine (
    .clk(clk), .rst(rst), .addr(phase_addr), .amp(amp_s)
  );

  assign amp_out = amp_s;
endmodule

// File: rtl/qmod_nco_chk.sv
module qmod_nco_chk #(
  parameter int PHASE_W = 48,
  parameter int ADDR_W  = 14,
  parameter int OUT_W   = 14
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] center_fw,
  input logic [PHASE_W-1:0] offset_fw,
  input logic               offset_en,
  input logic [PHASE_W-1:0] acc,
  input logic [ADDR_W-1:0]  addr,
  input logic [OUT_W-1:0]   amp_out
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (acc == '0 && amp_out == '0));

  // R2 R3 R4
  step_gated_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc == $past(acc) + $past(center_fw) + ($past(offset_en) ? $past(offset_fw) : '0));

  // R6
  no_most_neg_chk: assert property (@(posedge clk) disable iff (rst) amp_out != MOST_NEG);

  // R8
  upper_half_neg_chk: assert property (@(posedge clk) disable iff (rst)
    addr[ADDR_W-1] |-> ##2 $signed(amp_out) < 0);

  // R8
  lower_half_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !addr[ADDR_W-1] |-> ##2 $signed(amp_out) > 0);
endmodule

bind qmod_nco qmod_nco_chk #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .center_fw(center_fw), .offset_fw(offset_fw),
  .offset_en(offset_en), .acc(u_acc.acc_q), .addr(phase_addr), .amp_out(amp_out)
);

// File: tb/sim_qmod_nco.sv
module sim_qmod_nco;
  localparam int CLK_PERIOD = 8;
  localparam real PI2 = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] center_fw = '0;
  logic [47:0] offset_fw = '0;
  logic        offset_en = 1'b0;
  logic [1:0]  quad_sel = '0;
  logic [13:0] amp_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  qmod_nco u0 (.clk(clk), .rst(rst), .center_fw(center_fw), .offset_fw(offset_fw),
               .offset_en(offset_en), .quad_sel(quad_sel), .amp_out(amp_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_amp(logic [47:0] a, logic [1:0] qs);
    logic [13:0] p;
    real x;
    int m;
    p = a[47:34] + {qs, 12'b0};
    x = 8191.0 * $sin(PI2 * (real'(p) + 0.5) / 16384.0);
    m = $rtoi((x < 0.0 ? -x : x) + 0.5);
    return (x < 0.0) ? -m : m;
  endfunction

  // reference model on the same edges
  logic [47:0] m_acc = '0;
  logic [1:0]  m_sel = '0;
  int e_mid = 0;
  int e_out = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_out = 0; e_mid = 0; m_acc = '0; m_sel = '0;
    end else begin
      e_out = e_mid;
      e_mid = ref_amp(m_acc, m_sel);
      m_acc = m_acc + center_fw + (offset_en ? offset_fw : 48'd0);
      m_sel = quad_sel;
    end
  end

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expect_eq(tag, int'($signed(amp_out)), e_out);
    end
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  int a0, a1, a2, a3, a0b, hold;

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    run(3, "R1");
    @(negedge clk); rst = 1'b0;
    run(2, "R1");

    // R2 plain center stepping, R7 every sample at its due edge
    center_fw = 48'h0123_4567_89AB;
    run(40, "R2 R7");

    // R3 offset ignored while disabled
    offset_fw = 48'h7FFF_0000_1234;
    offset_en = 1'b0;
    run(30, "R3");
    offset_en = 1'b1;
    run(30, "R2");
    for (int i = 0; i < 20; i++) begin
      offset_en = $urandom() % 2;
      offset_fw = rnd48();
      run(3, "R3");
    end

    // R4 wrap: negative step and large step
    offset_en = 1'b0;
    center_fw = 48'hFFFF_FFFF_FFFF - 48'h0003_0000_0000;
    run(60, "R4");
    center_fw = 48'hF000_0000_0000;
    run(40, "R4");

    // R5 quadrant codes toggling
    center_fw = 48'h0000_8000_0000;
    for (int i = 0; i < 60; i++) begin
      quad_sel = 2'($urandom());
      run(1, "R5");
    end

    // R8 / R5 / R7 directed with a frozen phase
    @(negedge clk); rst = 1'b1; quad_sel = 2'd0; center_fw = '0; offset_en = 1'b0;
    run(2, "R1");
    rst = 1'b0;
    center_fw = 48'h1234_5678_9ABC;
    run(1, "R2");
    center_fw = '0;
    run(4, "R6");
    a0 = int'($signed(amp_out));
    quad_sel = 2'd2; run(4, "R5");
    a2 = int'($signed(amp_out));
    expect_eq("R8 half-turn negation", a2, -a0);
    quad_sel = 2'd1; run(4, "R5");
    a1 = int'($signed(amp_out));
    quad_sel = 2'd3; run(4, "R5");
    a3 = int'($signed(amp_out));
    expect_eq("R8 half-turn negation", a3, -a1);
    quad_sel = 2'd0; run(4, "R5");
    a0b = int'($signed(amp_out));
    expect_eq("R5 accumulator untouched", a0b, a0);

    // R7 explicit latency: unchanged for two falling edges, new on the third
    hold = a0b;
    quad_sel = 2'd2;
    @(negedge clk); expect_eq("R7 edge1", int'($signed(amp_out)), hold);
    @(negedge clk); expect_eq("R7 edge2", int'($signed(amp_out)), hold);
    @(negedge clk); expect_eq("R7 edge3", int'($signed(amp_out)), -a0);

    // R6 random mix
    for (int i = 0; i < 1500; i++) begin
      if ($urandom() % 8 == 0) center_fw = rnd48();
      if ($urandom() % 8 == 0) offset_fw = rnd48();
      if ($urandom() % 4 == 0) offset_en = $urandom() % 2;
      if ($urandom() % 4 == 0) quad_sel = 2'($urandom());
      run(1, "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule